// File: doc/BRIEF.md
# Almost-Empty Status Bus Controller

This block decides when one device of a multi-queue buffer owns a shared bus of almost-empty status bits, one bit per queue, and what it puts there. A level on the mode pin, captured once after master reset, selects one of two ways of sharing the bus among several devices.

In polled mode a single token circulates around a ring of devices. The device holding the token drives its queue status onto the bus for one read-clock cycle, raises its sync output for that cycle and presents the token on its token output, which the next device samples on the following edge. In direct mode, an external strobe together with an address picks the one device that drives the bus. That device keeps driving, refreshing its status every cycle, until another strobed address selects a different device.

Neither mode does anything until the device reports that its programming is complete. The output enable models the tri-state control of the shared bus. When the device does not drive, its status lines are held at zero.

Top module: `aeflag_bus_ctrl`

## Requirements
- R1: While master reset (active low) is asserted, the output enable, status bits, sync and token output are all low.
- R2: The mode pin is captured on the first read-clock edge after reset release. High means polled and low means direct. Changes to the pin after that edge have no effect until the next reset.
- R3: While the ready input is low, no strobe selects the device and no token is started.
- R4: In polled mode, a device whose INIT_TOKEN parameter is 1 takes the token on the first edge with ready high after the mode capture. It then drives the bus for the next cycle.
- R5: In polled mode, once started, the token register takes the token input on every edge. The device drives the bus for exactly the cycle after each edge on which the token input was high, and the token output is high in that same cycle.
- R6: The sync output is high in exactly the cycles in which this device drives the bus in polled mode.
- R7: In direct mode, an edge with the strobe high, ready high and an address equal to DEV_ID selects the device, which drives the bus from the next cycle on.
- R8: In direct mode, a strobe with any other address deselects the device. While the strobe is low, the selection is held.
- R9: While driving, the status bits show the per-queue status sampled at the preceding edge. While not driving, both the output enable and the status bits are zero.
- R10: In direct mode, the token input is ignored and sync and the token output stay low. In polled mode, the strobe is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_rd | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous active-low master reset |
| mode_pin_i | input | 1 | Mode selection, 1 polled, 0 direct, captured after reset |
| ready_i | input | 1 | Device programming complete |
| strobe_i | input | 1 | Direct-mode selection strobe |
| addr_i | input | ADDR_W | Direct-mode device address |
| tok_in_i | input | 1 | Token from previous device in the ring |
| q_status_i | input | NQ | Almost-empty bit per queue |
| status_o | output | NQ | Status bus value |
| status_oe_o | output | 1 | Bus drive enable |
| sync_o | output | 1 | High while this device's status is on the bus (polled) |
| tok_out_o | output | 1 | Token to next device in the ring |

## Verification
Polled operation is tried three ways. A lone start pulse shows that the initial token lasts one cycle. A later single-cycle token input, arriving while neighbours are emulated, shows a clean hand-off. A looped-back token shows continuous ownership with status following the queue bits cycle by cycle. Direct operation is tried with a strobe before ready, a strobe with a foreign address, a matching strobe, a held selection with the strobe low and a stray token, and a deselecting strobe. Together these separate selection, holding and ignoring. Toggling the mode pin after capture in both modes shows that the mode is frozen.

// File: rtl/aeflag_pkg.sv
package aeflag_pkg;
  typedef enum logic {
    MODE_DIRECT = 1'b0,
    MODE_POLLED = 1'b1
  } flag_mode_e;
endpackage

// File: rtl/aeflag_mode_latch.sv
module aeflag_mode_latch
  import aeflag_pkg::*;
(
  input  logic       clk_rd,
  input  logic       rst_n,
  input  logic       mode_pin_i,
  output logic       armed_o,
  output flag_mode_e mode_o
);
  logic       armed_q, armed_d;
  flag_mode_e mode_q, mode_d;

  always_comb begin
    armed_d = 1'b1;
    mode_d  = armed_q ? mode_q : flag_mode_e'(mode_pin_i);
  end

  always_ff @(posedge clk_rd or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      mode_q  <= MODE_DIRECT;
    end else begin
      armed_q <= armed_d;
      mode_q  <= mode_d;
    end
  end

  assign armed_o = armed_q;
  assign mode_o  = mode_q;

  AST_MODE_FROZEN: assert property (@(posedge clk_rd) disable iff (!rst_n)
    armed_q |=> (mode_q == $past(mode_q))); // R2
endmodule

// File: rtl/aeflag_direct_sel.sv
module aeflag_direct_sel #(
  parameter int ADDR_W = 3,
  parameter int DEV_ID = 2
) (
  input  logic              clk_rd,
  input  logic              rst_n,
  input  logic              enable_i,
  input  logic              ready_i,
  input  logic              strobe_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              sel_nx_o,
  output logic              sel_o
);
  localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(DEV_ID);

  logic sel_q, sel_d;
  logic take;

  always_comb begin
    take  = enable_i && ready_i && strobe_i;
    sel_d = sel_q;
    if (take) sel_d = (addr_i == MY_ADDR);
  end

  always_ff @(posedge clk_rd or negedge rst_n) begin
    if (!rst_n) sel_q <= 1'b0;
    else        sel_q <= sel_d;
  end

  assign sel_nx_o = sel_d;
  assign sel_o    = sel_q;

  AST_HOLD_NO_STROBE: assert property (@(posedge clk_rd) disable iff (!rst_n)
    !strobe_i |=> (sel_q == $past(sel_q))); // R8
  AST_NO_SEL_UNREADY: assert property (@(posedge clk_rd) disable iff (!rst_n)
    (!ready_i && !sel_q) |=> !sel_q); // R3
endmodule

// File: rtl/aeflag_token_ring.sv
module aeflag_token_ring #(
  parameter bit INIT_TOKEN = 1'b1
) (
  input  logic clk_rd,
  input  logic rst_n,
  input  logic enable_i,
  input  logic ready_i,
  input  logic tok_in_i,
  output logic tok_nx_o,
  output logic tok_o
);
  logic tok_q, tok_d;
  logic started_q, started_d;

  always_comb begin
    tok_d     = tok_q;
    started_d = started_q;
    if (enable_i) begin
      if (started_q) begin
        tok_d = tok_in_i;
      end else if (ready_i) begin
        started_d = 1'b1;
        tok_d     = INIT_TOKEN;
      end
    end
  end

  always_ff @(posedge clk_rd or negedge rst_n) begin
    if (!rst_n) begin
      tok_q     <= 1'b0;
      started_q <= 1'b0;
    end else begin
      tok_q     <= tok_d;
      started_q <= started_d;
    end
  end

  assign tok_nx_o = tok_d;
  assign tok_o    = tok_q;

  AST_TOKEN_PASSES: assert property (@(posedge clk_rd) disable iff (!rst_n)
    started_q |=> (tok_q == $past(tok_in_i))); // R5
  AST_NO_START_UNREADY: assert property (@(posedge clk_rd) disable iff (!rst_n)
    (!started_q && !ready_i) |=> !tok_q); // R3
endmodule

// File: rtl/aeflag_bus_ctrl.sv
module aeflag_bus_ctrl
  import aeflag_pkg::*;
#(
  parameter int ADDR_W     = 3,
  parameter int NQ         = 4,
  parameter int DEV_ID     = 2,
  parameter bit INIT_TOKEN = 1'b1
) (
  input  logic              clk_rd,
  input  logic              rst_n,
  input  logic              mode_pin_i,
  input  logic              ready_i,
  input  logic              strobe_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              tok_in_i,
  input  logic [NQ-1:0]     q_status_i,
  output logic [NQ-1:0]     status_o,
  output logic              status_oe_o,
  output logic              sync_o,
  output logic              tok_out_o
);
  logic       armed;
  flag_mode_e mode;
  logic       poll_en, direct_en;
  logic       sel_nx, sel;
  logic       tok_nx, tok;
  logic       drive_nx;

  logic [NQ-1:0] status_q, status_d;
  logic          oe_q, oe_d;

  aeflag_mode_latch u_mode (
    .clk_rd     (clk_rd),
    .rst_n      (rst_n),
    .mode_pin_i (mode_pin_i),
    .armed_o    (armed),
    .mode_o     (mode)
  );

  assign poll_en   = armed && (mode == MODE_POLLED);
  assign direct_en = armed && (mode == MODE_DIRECT);

  aeflag_direct_sel #(
    .ADDR_W (ADDR_W),
    .DEV_ID (DEV_ID)
  ) u_direct (
    .clk_rd   (clk_rd),
    .rst_n    (rst_n),
    .enable_i (direct_en),
    .ready_i  (ready_i),
    .strobe_i (strobe_i),
    .addr_i   (addr_i),
    .sel_nx_o (sel_nx),
    .sel_o    (sel)
  );

  aeflag_token_ring #(
    .INIT_TOKEN (INIT_TOKEN)
  ) u_ring (
    .clk_rd   (clk_rd),
    .rst_n    (rst_n),
    .enable_i (poll_en),
    .ready_i  (ready_i),
    .tok_in_i (tok_in_i),
    .tok_nx_o (tok_nx),
    .tok_o    (tok)
  );

  always_comb begin
    drive_nx = sel_nx || tok_nx;
    oe_d     = drive_nx;
    status_d = drive_nx ? q_status_i : '0;
  end

  always_ff @(posedge clk_rd or negedge rst_n) begin
    if (!rst_n) begin
      oe_q     <= 1'b0;
      status_q <= '0;
    end else begin
      oe_q     <= oe_d;
      status_q <= status_d;
    end
  end

  assign status_o    = status_q;
  assign status_oe_o = oe_q;
  assign sync_o      = tok;
  assign tok_out_o   = tok;

  AST_ONE_SOURCE: assert property (@(posedge clk_rd) disable iff (!rst_n)
    !(sel && tok)); // R10
  AST_QUIET_IDLE: assert property (@(posedge clk_rd) disable iff (!rst_n)
    !status_oe_o |-> (status_o == '0)); // R9
  AST_SYNC_ON_BUS: assert property (@(posedge clk_rd) disable iff (!rst_n)
    sync_o |-> status_oe_o); // R6
  AST_DIRECT_NO_TOKEN: assert property (@(posedge clk_rd) disable iff (!rst_n)
    (armed && (mode == MODE_DIRECT)) |-> !tok_out_o); // R10
endmodule

// File: tb/aeflag_bus_ctrl_tb_top.sv
module aeflag_bus_ctrl_tb_top;
  localparam int ADDR_W = 3;
  localparam int NQ     = 4;

  logic              clk_rd = 1'b0;
  logic              rst_n;
  logic              mode_pin;
  logic              ready;
  logic              strobe;
  logic [ADDR_W-1:0] addr;
  logic              tb_tok;
  logic              loop_en;
  logic [NQ-1:0]     qst;
  logic [NQ-1:0]     status;
  logic              oe, sync, tok_out;
  logic              tok_in;

  int checks = 0;
  int errors = 0;

  always #2 clk_rd = ~clk_rd;

  assign tok_in = loop_en ? tok_out : tb_tok;

  aeflag_bus_ctrl #(
    .ADDR_W     (ADDR_W),
    .NQ         (NQ),
    .DEV_ID     (2),
    .INIT_TOKEN (1'b1)
  ) dut_i (
    .clk_rd      (clk_rd),
    .rst_n       (rst_n),
    .mode_pin_i  (mode_pin),
    .ready_i     (ready),
    .strobe_i    (strobe),
    .addr_i      (addr),
    .tok_in_i    (tok_in),
    .q_status_i  (qst),
    .status_o    (status),
    .status_oe_o (oe),
    .sync_o      (sync),
    .tok_out_o   (tok_out)
  );

  task automatic tick();
    @(posedge clk_rd);
    #1;
  endtask

  // expected layout: {oe, status[3:0], sync, tok_out}
  task automatic chk(string req, logic e_oe, logic [NQ-1:0] e_st, logic e_sy, logic e_to);
    logic [NQ+2:0] act, exp;
    act = {oe, status, sync, tok_out};
    exp = {e_oe, e_st, e_sy, e_to};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual oe/st/sync/tok=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset(logic mode);
    rst_n = 1'b0; mode_pin = mode; ready = 1'b0; strobe = 1'b0;
    addr = '0; tb_tok = 1'b0; loop_en = 1'b0; qst = '0;
    tick(); tick();
    chk("R1 reset quiet", 1'b0, 4'h0, 1'b0, 1'b0);
    rst_n = 1'b1;
    tick(); // mode capture edge
  endtask

  task automatic test_polled_chain();
    do_reset(1'b1);
    qst = 4'hA;
    tick();
    chk("R3 no token before ready", 1'b0, 4'h0, 1'b0, 1'b0);
    ready = 1'b1; qst = 4'h5;
    tick();
    chk("R4 initial token", 1'b1, 4'h5, 1'b1, 1'b1);
    tb_tok = 1'b0;
    tick();
    chk("R5 token leaves", 1'b0, 4'h0, 1'b0, 1'b0);
    mode_pin = 1'b0; strobe = 1'b1; addr = 3'd2;
    tick();
    chk("R10 strobe ignored in polled", 1'b0, 4'h0, 1'b0, 1'b0);
    strobe = 1'b0; tb_tok = 1'b1; qst = 4'h3;
    tick();
    chk("R2 R5 R6 token returns, mode frozen", 1'b1, 4'h3, 1'b1, 1'b1);
    tb_tok = 1'b0;
    tick();
    chk("R6 sync one cycle", 1'b0, 4'h0, 1'b0, 1'b0);
  endtask

  task automatic test_polled_loop();
    do_reset(1'b1);
    ready = 1'b1; loop_en = 1'b1; qst = 4'h9;
    tick();
    chk("R4 loop start", 1'b1, 4'h9, 1'b1, 1'b1);
    for (int i = 0; i < 4; i++) begin
      qst = 4'(i * 3 + 1);
      tick();
      chk("R9 R6 loop status follows", 1'b1, 4'(i * 3 + 1), 1'b1, 1'b1);
    end
    loop_en = 1'b0;
  endtask

  task automatic test_direct();
    do_reset(1'b0);
    strobe = 1'b1; addr = 3'd2; qst = 4'h7;
    tick();
    chk("R3 strobe before ready", 1'b0, 4'h0, 1'b0, 1'b0);
    ready = 1'b1; addr = 3'd5;
    tick();
    chk("R8 foreign address", 1'b0, 4'h0, 1'b0, 1'b0);
    addr = 3'd2; qst = 4'hC;
    tick();
    chk("R7 selected", 1'b1, 4'hC, 1'b0, 1'b0);
    strobe = 1'b0; addr = 3'd5; qst = 4'h6; tb_tok = 1'b1;
    tick();
    chk("R8 R10 held, token ignored", 1'b1, 4'h6, 1'b0, 1'b0);
    mode_pin = 1'b1; qst = 4'hE;
    tick();
    chk("R2 mode frozen in direct", 1'b1, 4'hE, 1'b0, 1'b0);
    strobe = 1'b1; addr = 3'd1;
    tick();
    chk("R8 deselected", 1'b0, 4'h0, 1'b0, 1'b0);
    strobe = 1'b0; tb_tok = 1'b0;
    tick();
    chk("R9 idle bus quiet", 1'b0, 4'h0, 1'b0, 1'b0);
  endtask

  initial begin
    #(4 * 20000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    test_polled_chain();
    test_polled_loop();
    test_direct();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule